// File: doc/BRIEF.md
# LED Status Display Scanner

This block refreshes a bank of external eight-output addressable latches that drive the status lamps of an eight-port repeater. Five latches share one 3-bit address bus, and each latch takes one data line. The scanner walks the address from 0 to 7. At every address it puts one row of five status bits on the data lines and pulses a common write strobe. Each latch output therefore ends up holding one kind of indicator for one address.

Row 0 is not a port row. It carries the hub-wide flags: any-port collision, any-port reception, any-port jabbering and any-port partitioned. Rows 1 to 7 carry the collision, reception, partitioned, link and inverted-receive-polarity flags of the port with that number. The meaning of a latched bit therefore depends on the address.

A periodic tick starts a scan. A pause handshake lets a bus arbiter take the shared address and data lines between two addresses.

Top module: `led_scan_top`

## Requirements
- R1: After reset `led_addr` is 0, `led_data` is 0, and `led_wr`, `scan_busy` and `pause_ack` are 0 while `pause_req` is 0.
- R2: A scan writes the addresses 0,1,2,...,7 in rising order, with exactly one `led_wr` pulse for each address.
- R3: Each address first has one setup cycle with `led_wr` low. Then `led_wr` is high for exactly one cycle. The first pulse comes in the second cycle after the edge that samples `scan_tick`, and consecutive pulses are 3 cycles apart when the scan is not paused.
- R4: `led_addr` and `led_data` stay constant from the setup cycle through the strobe cycle and the hold cycle. The row data is captured at the clock edge that enters the setup cycle, so status changes after that edge do not reach that address.
- R5: At address 0 the data bits are D0=`any_col`, D1=`any_rec`, D2=`any_jab`, D3=`any_part` and D4=0. Bit 0 of the per-port vectors has no effect.
- R6: At address n, for n from 1 to 7, the data bits are D0=`port_col[n]`, D1=`port_rec[n]`, D2=`port_part[n]`, D3=`port_link[n]` and D4=`port_badpol[n]`.
- R7: `scan_tick` is accepted only while the block is idle and `pause_req` is low. A tick that comes during a scan starts nothing, and no second scan follows.
- R8: `scan_busy` is high from the cycle after the start edge until the cycle after the hold cycle of address 7, and low at all other times.
- R9: `pause_req` is sampled at the end of each hold cycle. If it is high there, the scanner stops in the next cycle with `pause_ack` high and `scan_busy` still high, and it issues no strobe. When `pause_req` falls, the setup cycle of the next address follows one edge later.
- R10: While the block is idle, `pause_ack` follows `pause_req` in the same cycle, and a tick that comes during that time is not accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| scan_tick | input | 1 | Periodic request to start a scan |
| pause_req | input | 1 | Arbiter request to stop the scanner between addresses |
| port_col | input | 8 | Per-port collision flags, bit n = port n |
| port_rec | input | 8 | Per-port reception flags |
| port_part | input | 8 | Per-port partitioned flags |
| port_link | input | 8 | Per-port link flags |
| port_badpol | input | 8 | Per-port inverted receive polarity flags |
| any_col | input | 1 | Collision seen on any port |
| any_rec | input | 1 | Reception on any port |
| any_jab | input | 1 | Any port jabbering |
| any_part | input | 1 | Any port partitioned |
| led_addr | output | 3 | Latch output select |
| led_data | output | 5 | One data bit per latch |
| led_wr | output | 1 | Latch write strobe |
| scan_busy | output | 1 | Scan in progress (also while paused) |
| pause_ack | output | 1 | Scanner stopped and lines free |

## Verification
Two things can land on the same clock edge: the end of an address's hold cycle, where the scanner would step to the next address, and a rising `pause_req` from the arbiter. The bench raises `pause_req` in the strobe cycle of address 2. It then expects `pause_ack` exactly two cycles later, no strobe for as long as the request is held, and address 3 strobed two cycles after the release. A second collision is a tick that arrives during a scan or during an idle pause. In both cases the bench expects no extra strobe and `scan_busy` low afterwards.

// File: rtl/led_scan_pkg.sv
package led_scan_pkg;

  localparam int unsigned LED_DW = 5;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SETUP,
    ST_STROBE,
    ST_HOLD,
    ST_PAUSE
  } scan_state_e;

  // Row 0 word: hub-wide flags, top bit unused.
  function automatic logic [LED_DW-1:0] hub_word(
    input logic a_col, input logic a_rec,
    input logic a_jab, input logic a_part);
    return {1'b0, a_part, a_jab, a_rec, a_col};
  endfunction

  // Port row word: one flag kind per data line.
  function automatic logic [LED_DW-1:0] port_word(
    input logic col, input logic rec, input logic part,
    input logic link, input logic badpol);
    return {badpol, link, part, rec, col};
  endfunction

endpackage

// File: rtl/led_scan_seq.sv
module led_scan_seq
  import led_scan_pkg::*;
#(
  parameter int unsigned NUM_ROWS = 8,
  localparam int unsigned AW = $clog2(NUM_ROWS)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  logic          pause_req,
  output logic [AW-1:0] addr,
  output logic [AW-1:0] next_addr,
  output logic          load,
  output logic          start,
  output logic          wr,
  output logic          busy,
  output logic          ack,
  output logic          in_setup,
  output logic          in_hold
);

  scan_state_e state, state_nx;
  logic        last_row;
  logic        step;

  assign last_row  = (addr == AW'(NUM_ROWS - 1));
  assign start     = (state == ST_IDLE) && tick && !pause_req;
  assign step      = ((state == ST_HOLD) && !last_row && !pause_req) ||
                     ((state == ST_PAUSE) && !pause_req);
  assign load      = start || step;
  assign next_addr = start ? '0 : addr + 1'b1;

  always_comb begin
    state_nx = state;
    unique case (state)
      ST_IDLE:   if (start) state_nx = ST_SETUP;
      ST_SETUP:  state_nx = ST_STROBE;
      ST_STROBE: state_nx = ST_HOLD;
      ST_HOLD: begin
        if (last_row)       state_nx = ST_IDLE;
        else if (pause_req) state_nx = ST_PAUSE;
        else                state_nx = ST_SETUP;
      end
      ST_PAUSE:  if (!pause_req) state_nx = ST_SETUP;
      default:   state_nx = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state <= ST_IDLE;
      addr  <= '0;
    end else begin
      state <= state_nx;
      if (load) addr <= next_addr;
    end
  end

  assign wr       = (state == ST_STROBE);
  assign busy     = (state != ST_IDLE);
  assign in_setup = (state == ST_SETUP);
  assign in_hold  = (state == ST_HOLD);
  assign ack      = pause_req && ((state == ST_IDLE) || (state == ST_PAUSE));

endmodule

// File: rtl/led_row_mux.sv
module led_row_mux
  import led_scan_pkg::*;
#(
  parameter int unsigned NUM_ROWS = 8,
  localparam int unsigned AW = $clog2(NUM_ROWS)
) (
  input  logic [AW-1:0]       sel,
  input  logic [NUM_ROWS-1:0] col,
  input  logic [NUM_ROWS-1:0] rec,
  input  logic [NUM_ROWS-1:0] part,
  input  logic [NUM_ROWS-1:0] link,
  input  logic [NUM_ROWS-1:0] badpol,
  input  logic                a_col,
  input  logic                a_rec,
  input  logic                a_jab,
  input  logic                a_part,
  output logic [LED_DW-1:0]   word
);

  logic [LED_DW-1:0] rows [NUM_ROWS];

  for (genvar r = 0; r < NUM_ROWS; r++) begin : g_row
    if (r == 0) begin : g_hub
      assign rows[r] = hub_word(a_col, a_rec, a_jab, a_part);
    end else begin : g_port
      assign rows[r] = port_word(col[r], rec[r], part[r], link[r], badpol[r]);
    end
  end

  assign word = rows[sel];

endmodule

// File: rtl/led_scan_top.sv
module led_scan_top
  import led_scan_pkg::*;
#(
  parameter int unsigned NUM_ROWS = 8,
  localparam int unsigned AW = $clog2(NUM_ROWS)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                scan_tick,
  input  logic                pause_req,
  input  logic [NUM_ROWS-1:0] port_col,
  input  logic [NUM_ROWS-1:0] port_rec,
  input  logic [NUM_ROWS-1:0] port_part,
  input  logic [NUM_ROWS-1:0] port_link,
  input  logic [NUM_ROWS-1:0] port_badpol,
  input  logic                any_col,
  input  logic                any_rec,
  input  logic                any_jab,
  input  logic                any_part,
  output logic [AW-1:0]       led_addr,
  output logic [LED_DW-1:0]   led_data,
  output logic                led_wr,
  output logic                scan_busy,
  output logic                pause_ack
);

  logic [AW-1:0]     seq_next_addr;
  logic              seq_load;
  logic              seq_start;
  logic              seq_setup;
  logic              seq_hold;
  logic [LED_DW-1:0] row_word;
  logic [LED_DW-1:0] data_q;

  led_scan_seq #(.NUM_ROWS(NUM_ROWS)) u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .tick      (scan_tick),
    .pause_req (pause_req),
    .addr      (led_addr),
    .next_addr (seq_next_addr),
    .load      (seq_load),
    .start     (seq_start),
    .wr        (led_wr),
    .busy      (scan_busy),
    .ack       (pause_ack),
    .in_setup  (seq_setup),
    .in_hold   (seq_hold)
  );

  led_row_mux #(.NUM_ROWS(NUM_ROWS)) u_mux (
    .sel    (seq_next_addr),
    .col    (port_col),
    .rec    (port_rec),
    .part   (port_part),
    .link   (port_link),
    .badpol (port_badpol),
    .a_col  (any_col),
    .a_rec  (any_rec),
    .a_jab  (any_jab),
    .a_part (any_part),
    .word   (row_word)
  );

  // Snapshot the row when its address is loaded (R4).
  always_ff @(posedge clk) begin
    if (!rst_n)        data_q <= '0;
    else if (seq_load) data_q <= row_word;
  end

  assign led_data = data_q;

endmodule

// File: rtl/led_scan_chk.sv
module led_scan_chk #(
  parameter int unsigned AW = 3,
  parameter int unsigned DW = 5
) (
  input logic          clk,
  input logic          rst_n,
  input logic [AW-1:0] addr,
  input logic [DW-1:0] data,
  input logic          wr,
  input logic          busy,
  input logic          ack,
  input logic          start,
  input logic          load,
  input logic          in_setup,
  input logic          in_hold
);

  p_setup_before_wr_r3: assert property (@(posedge clk) disable iff (!rst_n)
    wr |-> $past(in_setup));

  p_wr_one_cycle_r3: assert property (@(posedge clk) disable iff (!rst_n)
    wr |=> (in_hold && !wr));

  p_lines_stable_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr || in_hold) |-> ($stable(addr) && $stable(data)));

  p_first_addr_r2: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> (addr == '0));

  p_addr_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (load && !start) |=> (addr == $past(addr) + 1'b1));

  p_start_only_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
    start |-> !busy);

  p_busy_after_start_r8: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> busy);

  p_ack_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ack |-> (!wr && !in_setup && !in_hold));

  p_paused_no_wr_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (ack && busy) |=> !wr);

endmodule

bind led_scan_top led_scan_chk #(.AW(AW), .DW(led_scan_pkg::LED_DW)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .addr     (led_addr),
  .data     (led_data),
  .wr       (led_wr),
  .busy     (scan_busy),
  .ack      (pause_ack),
  .start    (seq_start),
  .load     (seq_load),
  .in_setup (seq_setup),
  .in_hold  (seq_hold)
);

// File: tb/led_scan_top_test.sv
module led_scan_top_test;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       scan_tick = 1'b0;
  logic       pause_req = 1'b0;
  logic [7:0] port_col = '0, port_rec = '0, port_part = '0, port_link = '0, port_badpol = '0;
  logic       any_col = 1'b0, any_rec = 1'b0, any_jab = 1'b0, any_part = 1'b0;
  logic [2:0] led_addr;
  logic [4:0] led_data;
  logic       led_wr, scan_busy, pause_ack;

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;

  always #10 clk = ~clk;

  led_scan_top uut (
    .clk(clk), .rst_n(rst_n), .scan_tick(scan_tick), .pause_req(pause_req),
    .port_col(port_col), .port_rec(port_rec), .port_part(port_part),
    .port_link(port_link), .port_badpol(port_badpol),
    .any_col(any_col), .any_rec(any_rec), .any_jab(any_jab), .any_part(any_part),
    .led_addr(led_addr), .led_data(led_data), .led_wr(led_wr),
    .scan_busy(scan_busy), .pause_ack(pause_ack)
  );

  // {col, rec, part, link, badpol, globals{part,jab,rec,col}}
  localparam logic [43:0] VEC [4] = '{
    {8'hFF, 8'h00, 8'h00, 8'h00, 8'h00, 4'b0000},
    {8'h55, 8'hAA, 8'h0F, 8'hF0, 8'h3C, 4'b0101},
    {8'h01, 8'h01, 8'h01, 8'h01, 8'h01, 4'b1111},
    {8'h92, 8'h24, 8'h48, 8'hFE, 8'h81, 4'b1010}
  };

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic logic [4:0] expect_word(input int a, input logic [43:0] v);
    logic [7:0] c, r, p, l, b;
    logic [3:0] g;
    {c, r, p, l, b, g} = v;
    if (a == 0) return {1'b0, g[3], g[2], g[1], g[0]};
    return {b[a], l[a], p[a], r[a], c[a]};
  endfunction

  task automatic apply(input logic [43:0] v);
    {port_col, port_rec, port_part, port_link, port_badpol,
     any_part, any_jab, any_rec, any_col} = v;
  endtask

  task automatic wait_wr(output int n);
    n = 0;
    do begin
      @(negedge clk);
      n++;
    end while (!led_wr && n < 40);
  endtask

  task automatic pulse_tick();
    @(negedge clk) scan_tick = 1'b1;
    @(negedge clk) scan_tick = 1'b0;
  endtask

  task automatic run_scan(input logic [43:0] v, input string req);
    int n;
    apply(v);
    pulse_tick();
    for (int a = 0; a < 8; a++) begin
      wait_wr(n);
      check(n == ((a == 0) ? 1 : 3), "R3", "strobe spacing", n, (a == 0) ? 1 : 3);
      check(led_addr == 3'(a), "R2", "address order", led_addr, a);
      check(led_data == expect_word(a, v), req, "row data", led_data, expect_word(a, v));
    end
    @(negedge clk);
    check(scan_busy == 1'b1, "R8", "busy in last hold", scan_busy, 1);
    @(negedge clk);
    check(scan_busy == 1'b0, "R8", "busy after scan", scan_busy, 0);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual %0d expected %0d", cyc, 100000);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    int n;
    int wrs;
    repeat (3) @(negedge clk);
    // R1 reset state
    check(led_addr == 0 && led_data == 0, "R1", "reset lines", {led_addr, led_data}, 0);
    check(!led_wr && !scan_busy && !pause_ack, "R1", "reset flags",
          {led_wr, scan_busy, pause_ack}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(!scan_busy && !led_wr, "R1", "idle after reset", {scan_busy, led_wr}, 0);

    // Vector table: R5 (row 0, bit 0 ignored) and R6 (port rows)
    foreach (VEC[i]) run_scan(VEC[i], (i % 2 == 0) ? "R5/R6" : "R6");

    // R4: snapshot taken at setup entry, later changes not shown
    apply(VEC[1]);
    pulse_tick();
    wait_wr(n);
    apply(VEC[3]);
    check(led_data == expect_word(0, VEC[1]), "R4", "data in strobe", led_data,
          expect_word(0, VEC[1]));
    @(negedge clk);
    check(led_data == expect_word(0, VEC[1]) && led_addr == 0, "R4", "data in hold",
          led_data, expect_word(0, VEC[1]));
    wait_wr(n);
    check(led_data == expect_word(1, VEC[3]), "R4", "next row new data", led_data,
          expect_word(1, VEC[3]));
    // R7: tick during the scan is ignored
    @(negedge clk) scan_tick = 1'b1;
    @(negedge clk) scan_tick = 1'b0;
    wrs = 0;
    for (int k = 0; k < 40; k++) begin
      @(negedge clk);
      if (led_wr) wrs++;
    end
    check(wrs == 6, "R7", "strobes after mid-scan tick", wrs, 6);
    check(!scan_busy, "R7", "no second scan", scan_busy, 0);

    // R9: pause between addresses
    apply(VEC[1]);
    pulse_tick();
    for (int a = 0; a < 3; a++) wait_wr(n);
    pause_req = 1'b1;
    @(negedge clk);
    check(!pause_ack, "R9", "no ack in hold", pause_ack, 0);
    @(negedge clk);
    check(pause_ack && scan_busy, "R9", "ack while paused", {pause_ack, scan_busy}, 3);
    wrs = 0;
    for (int k = 0; k < 6; k++) begin
      @(negedge clk);
      if (led_wr) wrs++;
    end
    check(wrs == 0 && scan_busy, "R9", "no strobes while paused", wrs, 0);
    pause_req = 1'b0;
    @(negedge clk);
    check(!led_wr && !pause_ack, "R9", "setup after release", {led_wr, pause_ack}, 0);
    @(negedge clk);
    check(led_wr && led_addr == 3, "R9", "resume at next address", led_addr, 3);
    check(led_data == expect_word(3, VEC[1]), "R6", "resumed row data", led_data,
          expect_word(3, VEC[1]));
    for (int a = 4; a < 8; a++) begin
      wait_wr(n);
      check(led_addr == 3'(a), "R2", "order after pause", led_addr, a);
    end
    repeat (2) @(negedge clk);
    check(!scan_busy, "R8", "idle after paused scan", scan_busy, 0);

    // R10: pause while idle
    pause_req = 1'b1;
    #1;
    check(pause_ack, "R10", "idle ack", pause_ack, 1);
    pulse_tick();
    wrs = 0;
    for (int k = 0; k < 6; k++) begin
      @(negedge clk);
      if (led_wr || scan_busy) wrs++;
    end
    check(wrs == 0, "R10", "tick refused while paused", wrs, 0);
    pause_req = 1'b0;
    #1;
    check(!pause_ack, "R10", "ack drops", pause_ack, 0);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule